// File: doc/BRIEF.md
# Command Channel Transfer Engine

This block is a memory-mapped command channel. A host programs it through four word registers: a command word, a completion status word and two 32-bit data words. Writing the command word starts one transaction that moves between one and eight bytes between the data words and a register array of downstream peripherals. The register array is built into the block and stands in for the serial bus. Each slave owns a small window of byte registers in it.

The command word packs a 5-bit opcode, a 4-bit slave id, a 16-bit register address and a 3-bit field that holds the byte count minus one. The engine moves one byte per clock cycle. When the transfer ends it raises a done flag. Three further flags report a failed command, a refused command and a command that was discarded because it arrived too early. A permission input that is low when a command is accepted forces the refused outcome, and no access is made.

For a write, the host loads the data words first and then writes the command. For a read, the host writes the command, polls status until done is set, and then reads the data words.

Top module: `cmdch_engine`

## Requirements
- R1: After reset, the status word, both data words and every byte of the peripheral register array read as zero.
- R2: The register offsets are: command 0x00, status 0x04, low data word 0x08 (bytes 0-3) and high data word 0x10 (bytes 4-7), with byte 0 in bits 7:0. The command fields are opcode in bits 31:27, slave id in bits 23:20, address in bits 19:4 and byte count minus one in bits 2:0. The status bits are done (bit 0), failure (bit 1), denied (bit 2) and dropped (bit 3).
- R3: Opcodes 0, 2 and 14 write bytes 0..n-1 of the data words, one byte per cycle, to consecutive register addresses of the slave. The array slot is formed from the low 2 bits of the slave id and the low 4 bits of the address, and the address wraps inside the slave's 16-byte window.
- R4: Opcodes 1, 13 and 15 read bytes 0..n-1 from the same slots into the data words. Every returned byte is in place in the same cycle that done becomes visible.
- R5: Opcode 16 stores data byte 0 at register 0 of the slave, and it ignores the address and count fields.
- R6: An accepted command clears all four status bits. Done stays low for at least the cycle after acceptance.
- R7: Any other opcode ends with status 0x3 (done and failure), and the array is not touched.
- R8: If the permission input is low when a command is accepted, the result is status 0x5 (done and denied), and the array is not touched.
- R9: A command write during a transaction sets dropped and is otherwise ignored. Dropped remains set, together with the running transaction's final done, until the next accepted command.
- R10: Host writes to the data words are ignored while a transaction is in progress.
- R11: Done, once set, remains set until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data, combinational from host_addr |
| access_ok | input | 1 | Permission; low at acceptance forces the denied outcome |

## Verification
The checker takes for granted that host_addr, host_we and host_wdata are stable around each rising edge. It also assumes that access_ok is valid in the cycle a command is written, because that is the cycle in which the permission and the opcode class are judged. The bench changes every input only at the falling clock edge and holds each write strobe for exactly one cycle. It raises a command while a transaction runs only where it wants the drop path, and it uses slave ids below four so that the array windows do not alias.

// File: rtl/cmdch_pkg.sv
package cmdch_pkg;
  localparam int unsigned HADDR_W = 5;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned XFER_MAX = 8;

  localparam logic [HADDR_W-1:0] OFF_CMD  = 5'h00;
  localparam logic [HADDR_W-1:0] OFF_STAT = 5'h04;
  localparam logic [HADDR_W-1:0] OFF_DLO  = 5'h08;
  localparam logic [HADDR_W-1:0] OFF_DHI  = 5'h10;

  // command word field positions
  localparam int unsigned OPC_LSB = 27;
  localparam int unsigned SID_LSB = 20;
  localparam int unsigned ADR_LSB = 4;

  typedef enum logic [1:0] {K_BAD, K_WRITE, K_READ, K_ZERO} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DENY, S_FAIL} st_e;

  typedef struct packed {
    logic dropped;
    logic denied;
    logic failure;
    logic done;
  } stat_t;

  function automatic kind_e classify(input logic [4:0] op);
    kind_e k;
    case (op)
      5'd0, 5'd2, 5'd14: k = K_WRITE;
      5'd1, 5'd13, 5'd15: k = K_READ;
      5'd16:              k = K_ZERO;
      default:            k = K_BAD;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/cmdch_rst_sync.sv
module cmdch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cmdch_periph.sv
module cmdch_periph #(
  parameter int unsigned SID_SEL = 2,
  parameter int unsigned REG_SEL = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SID_SEL+REG_SEL-1:0] idx,
  input  logic [7:0]                 wbyte,
  output logic [7:0]                 rbyte
);
  localparam int unsigned DEPTH = 1 << (SID_SEL + REG_SEL);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (wr_en) begin
      mem_q[idx] <= wbyte;
    end
  end

  assign rbyte = mem_q[idx];
endmodule

// File: rtl/cmdch_regs.sv
module cmdch_regs
  import cmdch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  input  logic               busy,
  input  stat_t              stat,
  input  logic               eng_we,
  input  logic [2:0]         eng_idx,
  input  logic [7:0]         eng_byte,
  output logic [8*XFER_MAX-1:0] data_bytes
);
  logic [8*XFER_MAX-1:0] data_q, data_d;
  logic                  data_en;

  always_comb begin
    data_d  = data_q;
    data_en = 1'b0;
    if (eng_we) begin
      data_d[{eng_idx, 3'b000} +: 8] = eng_byte;
      data_en = 1'b1;
    end else if (host_we && !busy) begin
      if (host_addr == OFF_DLO) begin
        data_d[31:0] = host_wdata;
        data_en = 1'b1;
      end else if (host_addr == OFF_DHI) begin
        data_d[63:32] = host_wdata;
        data_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_comb begin
    case (host_addr)
      OFF_STAT: host_rdata = {28'h0, stat};
      OFF_DLO:  host_rdata = data_q[31:0];
      OFF_DHI:  host_rdata = data_q[63:32];
      default:  host_rdata = '0;
    endcase
  end

  assign data_bytes = data_q;
endmodule

// File: rtl/cmdch_seq.sv
module cmdch_seq
  import cmdch_pkg::*;
#(
  parameter int unsigned SID_SEL = 2,
  parameter int unsigned REG_SEL = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_wr,
  input  logic [4:0]                 cmd_op,
  input  logic [SID_SEL-1:0]         cmd_sid,
  input  logic [REG_SEL-1:0]         cmd_reg,
  input  logic [2:0]                 cmd_bc,
  input  logic                       access_ok,
  input  logic [8*XFER_MAX-1:0]      data_bytes,
  input  logic [7:0]                 periph_rbyte,
  output logic                       busy,
  output stat_t                      stat,
  output logic                       periph_we,
  output logic [SID_SEL+REG_SEL-1:0] periph_idx,
  output logic [7:0]                 periph_wbyte,
  output logic                       eng_we,
  output logic [2:0]                 eng_idx,
  output logic [7:0]                 eng_byte
);
  st_e                st_q, st_d;
  kind_e              kind_q, kind_d, kind_in;
  logic [SID_SEL-1:0] sid_q, sid_d;
  logic [REG_SEL-1:0] reg_q, reg_d, reg_off;
  logic [2:0]         bc_q, bc_d, k_q, k_d;
  stat_t              stat_q, stat_d;
  logic               accept;

  assign busy    = (st_q != S_IDLE);
  assign accept  = cmd_wr && !busy;
  assign kind_in = classify(cmd_op);

  always_comb begin
    st_d   = st_q;
    k_d    = k_q;
    stat_d = stat_q;
    kind_d = kind_in;
    sid_d  = cmd_sid;
    reg_d  = cmd_reg;
    bc_d   = cmd_bc;
    if (kind_in == K_ZERO) begin
      reg_d = '0;
      bc_d  = '0;
    end
    case (st_q)
      S_IDLE: begin
        if (cmd_wr) begin
          stat_d = '0;
          k_d    = '0;
          if (!access_ok)           st_d = S_DENY;
          else if (kind_in == K_BAD) st_d = S_FAIL;
          else                       st_d = S_XFER;
        end
      end
      S_XFER: begin
        if (k_q == bc_q) begin
          st_d        = S_IDLE;
          stat_d.done = 1'b1;
        end else begin
          k_d = k_q + 3'd1;
        end
      end
      S_DENY: begin
        st_d          = S_IDLE;
        stat_d.done   = 1'b1;
        stat_d.denied = 1'b1;
      end
      S_FAIL: begin
        st_d           = S_IDLE;
        stat_d.done    = 1'b1;
        stat_d.failure = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
    if (cmd_wr && busy) stat_d.dropped = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      k_q    <= '0;
      stat_q <= '0;
    end else begin
      st_q   <= st_d;
      k_q    <= k_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_BAD;
      sid_q  <= '0;
      reg_q  <= '0;
      bc_q   <= '0;
    end else if (accept) begin
      kind_q <= kind_d;
      sid_q  <= sid_d;
      reg_q  <= reg_d;
      bc_q   <= bc_d;
    end
  end

  assign reg_off      = reg_q + REG_SEL'(k_q);
  assign periph_idx   = {sid_q, reg_off};
  assign periph_we    = (st_q == S_XFER) && (kind_q == K_WRITE || kind_q == K_ZERO);
  assign periph_wbyte = data_bytes[{k_q, 3'b000} +: 8];
  assign eng_we       = (st_q == S_XFER) && (kind_q == K_READ);
  assign eng_idx      = k_q;
  assign eng_byte     = periph_rbyte;
  assign stat         = stat_q;
endmodule

// File: rtl/cmdch_engine.sv
module cmdch_engine
  import cmdch_pkg::*;
#(
  parameter int unsigned SID_SEL = 2,
  parameter int unsigned REG_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  input  logic               access_ok
);
  localparam int unsigned IDX_W = SID_SEL + REG_SEL;

  logic                  rst_sync_n;
  logic                  busy, cmd_wr;
  stat_t                 stat;
  logic                  periph_we, eng_we;
  logic [IDX_W-1:0]      periph_idx;
  logic [7:0]            periph_wbyte, periph_rbyte, eng_byte;
  logic [2:0]            eng_idx;
  logic [8*XFER_MAX-1:0] data_bytes;

  assign cmd_wr = host_we && (host_addr == OFF_CMD);

  cmdch_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cmdch_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .stat(stat),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_byte(eng_byte),
    .data_bytes(data_bytes)
  );

  cmdch_seq #(.SID_SEL(SID_SEL), .REG_SEL(REG_SEL)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .cmd_wr(cmd_wr),
    .cmd_op(host_wdata[OPC_LSB +: 5]),
    .cmd_sid(host_wdata[SID_LSB +: SID_SEL]),
    .cmd_reg(host_wdata[ADR_LSB +: REG_SEL]),
    .cmd_bc(host_wdata[2:0]), .access_ok(access_ok), .data_bytes(data_bytes),
    .periph_rbyte(periph_rbyte), .busy(busy), .stat(stat),
    .periph_we(periph_we), .periph_idx(periph_idx), .periph_wbyte(periph_wbyte),
    .eng_we(eng_we), .eng_idx(eng_idx), .eng_byte(eng_byte)
  );

  cmdch_periph #(.SID_SEL(SID_SEL), .REG_SEL(REG_SEL)) u_periph (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(periph_we), .idx(periph_idx),
    .wbyte(periph_wbyte), .rbyte(periph_rbyte)
  );
endmodule

// File: rtl/cmdch_engine_chk.sv
module cmdch_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_we,
  input logic [4:0] host_addr,
  input logic [4:0] cmd_op,
  input logic       access_ok,
  input logic       busy,
  input logic [3:0] stat,
  input logic       periph_we,
  input logic       eng_we
);
  logic cmd_hit, acc, bad_op;

  assign cmd_hit = host_we && (host_addr == 5'h00);
  assign acc     = cmd_hit && !busy;
  assign bad_op  = !(cmd_op inside {5'd0, 5'd1, 5'd2, 5'd13, 5'd14, 5'd15, 5'd16});

  // R6: acceptance clears status, done low next cycle
  p_clear_on_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (stat == 4'b0000));

  // R8: refused command reports done+denied, no access
  p_deny_noacc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !access_ok) |=> (!periph_we && !eng_we));
  p_deny_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !access_ok) |=> ##1 (stat[2:0] == 3'b101));

  // R7: unsupported opcode reports done+failure, no access
  p_bad_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && access_ok && bad_op) |=> (!periph_we && !eng_we) ##1 (stat[2:0] == 3'b011));

  // R9: command during a transaction sets dropped
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && busy) |=> stat[3]);

  // R11: done held until next accepted command
  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !cmd_hit) |=> stat[0]);

  // R3/R4: array and data-word traffic only while busy, never both
  p_access_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_we || eng_we) |-> (busy && !stat[0] && $onehot0({periph_we, eng_we})));
endmodule

bind cmdch_engine cmdch_engine_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_we(host_we), .host_addr(host_addr),
  .cmd_op(host_wdata[31:27]), .access_ok(access_ok), .busy(busy), .stat(stat),
  .periph_we(periph_we), .eng_we(eng_we)
);

// File: tb/cmdch_engine_bench.sv
module cmdch_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [4:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        access_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] mdl [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdch_engine u_cmdch_engine (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .access_ok(access_ok)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  function automatic logic [31:0] mk(input int op, input int sid, input int adr, input int cnt);
    logic [2:0] bc = 3'(cnt - 1);
    return {5'(op), 3'b000, 4'(sid), 16'(adr), 1'b0, bc};
  endfunction

  function automatic int slot(input int sid, input int adr);
    return (sid % 4) * 16 + (adr % 16);
  endfunction

  task automatic wait_done(input string req, output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 40; i++) begin
      hr(5'h04, st);
      if (st[0]) break;
      @(negedge clk);
    end
    if (!st[0]) chk(req, st, 32'h1);
  endtask

  // write transfer of cnt bytes from buf64, updates model
  task automatic do_write(input string req, input int op, input int sid, input int adr,
                          input int cnt, input logic [63:0] buf64);
    logic [31:0] st;
    hw(5'h08, buf64[31:0]);
    hw(5'h10, buf64[63:32]);
    hw(5'h00, mk(op, sid, adr, cnt));
    hr(5'h04, st);
    chk({req, " R6 done low after accept"}, st, 32'h0);
    wait_done(req, st);
    chk({req, " status"}, st, 32'h1);
    for (int k = 0; k < cnt; k++) mdl[slot(sid, adr + k)] = buf64[8*k +: 8];
  endtask

  // read transfer, compares data words to model (bytes past cnt keep pre-value)
  task automatic do_read(input string req, input int op, input int sid, input int adr,
                         input int cnt);
    logic [31:0] st, lo, hi;
    logic [63:0] exp;
    hw(5'h08, 32'h0);
    hw(5'h10, 32'h0);
    exp = '0;
    for (int k = 0; k < cnt; k++) exp[8*k +: 8] = mdl[slot(sid, adr + k)];
    hw(5'h00, mk(op, sid, adr, cnt));
    wait_done(req, st);
    chk({req, " status"}, st, 32'h1);
    hr(5'h08, lo);
    hr(5'h10, hi);
    chk({req, " low data"}, lo, exp[31:0]);
    chk({req, " high data"}, hi, exp[63:32]);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    hr(5'h04, v); chk("R1 status after reset", v, 32'h0);
    hr(5'h08, v); chk("R1 low data after reset", v, 32'h0);
    hr(5'h10, v); chk("R1 high data after reset", v, 32'h0);
    do_read("R1 array zero", 1, 3, 0, 8);
  endtask

  task automatic t_long_rw;
    do_write("R3 op0 4 bytes", 0, 1, 16'h0012, 4, 64'h0000_0000_A1B2_C3D4);
    do_read("R4 op1 4 bytes", 1, 1, 16'h0012, 4);
  endtask

  task automatic t_wrap8;
    do_write("R3 op2 8 bytes wrap", 2, 2, 16'h340E, 8, 64'h8877_6655_4433_2211);
    do_read("R4 op13 8 bytes wrap", 13, 2, 16'h340E, 8);
    do_read("R2 byte order offset read", 15, 2, 16'h0000, 2);
  endtask

  task automatic t_single;
    do_write("R3 op14 1 byte", 14, 0, 16'h0005, 1, 64'hFFFF_FFFF_FFFF_FF5A);
    do_read("R4 op15 1 byte", 15, 0, 16'h0005, 1);
    do_read("R3 neighbour untouched", 15, 0, 16'h0006, 1);
  endtask

  task automatic t_zero;
    logic [31:0] st;
    hw(5'h08, 32'h0000_00C7);
    hw(5'h00, mk(16, 3, 16'h0009, 5));
    wait_done("R5 zero-write", st);
    chk("R5 zero-write status", st, 32'h1);
    mdl[slot(3, 0)] = 8'hC7;
    do_read("R5 zero-write lands at reg 0", 1, 3, 0, 8);
    do_read("R5 zero-write ignores address", 1, 3, 16'h0009, 1);
  endtask

  task automatic t_badop;
    logic [31:0] st;
    hw(5'h08, 32'hDEAD_BEEF);
    hw(5'h00, mk(5, 1, 16'h0012, 4));
    hr(5'h04, st);
    chk("R6 done low after bad op accept", st, 32'h0);
    wait_done("R7 bad op", st);
    chk("R7 bad op status", st, 32'h3);
    do_read("R7 array untouched", 1, 1, 16'h0012, 4);
  endtask

  task automatic t_deny;
    logic [31:0] st;
    hw(5'h08, 32'h1234_5678);
    access_ok = 1'b0;
    hw(5'h00, mk(0, 1, 16'h0012, 4));
    access_ok = 1'b1;
    wait_done("R8 denied", st);
    chk("R8 denied status", st, 32'h5);
    do_read("R8 array untouched", 1, 1, 16'h0012, 4);
  endtask

  task automatic t_drop;
    logic [31:0] st;
    hw(5'h08, 32'h0403_0201);
    hw(5'h10, 32'h0807_0605);
    hw(5'h00, mk(0, 2, 16'h0000, 8));
    hw(5'h00, mk(0, 3, 16'h0004, 1));
    wait_done("R9 drop", st);
    chk("R9 done and dropped", st, 32'h9);
    repeat (3) @(negedge clk);
    hr(5'h04, st);
    chk("R11 status held", st, 32'h9);
    for (int k = 0; k < 8; k++) mdl[slot(2, k)] = 8'(k + 1);
    do_read("R9 first command completed", 1, 2, 0, 8);
    do_read("R9 dropped command had no effect", 1, 3, 16'h0004, 1);
  endtask

  task automatic t_busy_data;
    logic [31:0] st, lo, hi;
    hw(5'h00, mk(13, 2, 16'h0000, 8));
    hw(5'h08, 32'hCAFE_F00D);
    hw(5'h10, 32'hCAFE_F00D);
    wait_done("R10 busy data write", st);
    hr(5'h08, lo);
    hr(5'h10, hi);
    chk("R10 low data unchanged by host", lo, 32'h0403_0201);
    chk("R10 high data unchanged by host", hi, 32'h0807_0605);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0; access_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_long_rw();
    t_wrap8();
    t_single();
    t_zero();
    t_badop();
    t_deny();
    t_drop();
    t_busy_data();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule